// File: doc/BRIEF.md
# Mixed-Width Lane RAM

This block is a synchronous RAM. It keeps its contents as wide words and also gives access to them through narrow ports. The narrow data width equals the wide width divided by a power-of-two ratio. A narrow address is the wide word index with extra low bits appended. Those low bits pick one lane (a narrow slice) of that word.

Five ports share the same flop storage:
- a wide write port;
- a wide synchronous read port with an enable;
- a narrow masked write port;
- a narrow synchronous read port with an enable;
- a narrow combined port that reads whenever it is enabled and also writes when its write strobe is set.

Because all ports address the same words, data written through one width can be read back through the other.

A parameter selects the read-under-write policy, which applies when a read and a write hit the same word in the same cycle:
- **read-first:** the read returns the old contents.
- **write-first:** the read returns the new contents.
- **don't-care:** this is built as read-first.

Top module: `lane_ram`

## Requirements
- R1: While `rst` is high, every word is cleared, and at the next edge each read output is zero.
- R2: The word index of a narrow address is `addr >> log2(RATIO)`. The low `log2(RATIO)` bits give the lane. Lane 0 is bits [NW-1:0] of the word and lane k is bits [k*NW+NW-1:k*NW].
- R3: A narrow write alters only its own lane. Within the lane, mask bit g enables bits [4g+3:4g]. Unmasked groups and all other lanes keep their values.
- R4: A narrow read enabled in one cycle presents the selected lane on `nr_rdata` after the next rising edge.
- R5: A read port whose enable is low keeps its previous output, whatever its address does.
- R6: On the combined port:
  - with `nx_en` high, the addressed lane is read;
  - with `nx_en` and `nx_wr` both high, the masked write is performed as well;
  - with all mask bits zero, the stored data is unchanged.
- R7: A wide write updates the whole word at the edge. A wide read returns the word one edge after `wd_re`.
- R8: After a wide write, narrow reads of lanes 0 up to RATIO-1 return the word's slices, from the least significant slice upward.
- R9: Several writes to one word in the same cycle are applied in a fixed order, and later writes override earlier ones bit by bit. The order is: wide write first, then the narrow write port, then the combined port.
- R10: With the read-first or don't-care policy, a read that collides with same-cycle writes returns the contents from before those writes.
- R11: With the write-first policy, a colliding read returns the contents after all same-cycle writes.
- R12: Elaboration fails unless three conditions hold:
  - RATIO is a power of two and at least 2;
  - DEPTH is a power of two;
  - the narrow width is a multiple of the mask group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wd_we | input | 1 | Wide write strobe |
| wd_addr | input | log2(DEPTH) | Wide word index (write and read) |
| wd_wdata | input | WIDE_W | Wide write data |
| wd_re | input | 1 | Wide read enable |
| wd_rdata | output | WIDE_W | Wide read data |
| nw_en | input | 1 | Narrow write strobe |
| nw_addr | input | log2(DEPTH)+log2(RATIO) | Narrow write address |
| nw_data | input | WIDE_W/RATIO | Narrow write data |
| nw_mask | input | NW/4 | Narrow write mask, one bit per 4-bit group |
| nr_en | input | 1 | Narrow read enable |
| nr_addr | input | log2(DEPTH)+log2(RATIO) | Narrow read address |
| nr_rdata | output | WIDE_W/RATIO | Narrow read data |
| nx_en | input | 1 | Combined port enable (read) |
| nx_wr | input | 1 | Combined port write qualifier |
| nx_addr | input | log2(DEPTH)+log2(RATIO) | Combined port address |
| nx_wdata | input | WIDE_W/RATIO | Combined port write data |
| nx_mask | input | NW/4 | Combined port write mask |
| nx_rdata | output | WIDE_W/RATIO | Combined port read data |

## Verification
Every read result is due exactly one rising edge after the cycle in which its enable and address were presented. Every write is visible to a read presented in the following cycle. The bench changes inputs 1 ns after an edge and samples outputs 1 ns after the next edge, so each value is observed in the cycle it is due.

Collision cases are sampled at the same edge on two instances, one read-first and one write-first. This shows the old value and the new value side by side from identical stimulus.

// File: rtl/lane_ram_pkg.sv
package lane_ram_pkg;

    // Read-under-write policy selector.
    typedef enum logic [1:0] {
        RUW_READ_FIRST  = 2'd0,
        RUW_WRITE_FIRST = 2'd1,
        RUW_DONT_CARE   = 2'd2
    } ruw_e;

    // Granule width covered by one mask bit.
    localparam int unsigned MASK_GRAN = 4;

    // True when v is a non-zero power of two (R12).
    function automatic bit is_pow2(input int unsigned v);
        return (v != 0) && ((v & (v - 1)) == 0);
    endfunction

endpackage

// File: rtl/lane_ram_merge.sv
// Overlays one masked narrow lane onto a wide word.
module lane_ram_merge
    import lane_ram_pkg::*;
#(
    parameter int unsigned WIDE_W   = 32,
    parameter int unsigned NARROW_W = 8,
    parameter int unsigned LANE_W   = 2,
    localparam int unsigned RATIO   = WIDE_W / NARROW_W,
    localparam int unsigned MASK_W  = NARROW_W / MASK_GRAN
) (
    input  logic [WIDE_W-1:0]   word_i,
    input  logic                en_i,
    input  logic [LANE_W-1:0]   lane_i,
    input  logic [NARROW_W-1:0] data_i,
    input  logic [MASK_W-1:0]   mask_i,
    output logic [WIDE_W-1:0]   word_o
);

    for (genvar l = 0; l < RATIO; l++) begin : g_lane
        for (genvar g = 0; g < MASK_W; g++) begin : g_grp
            localparam int unsigned BASE = l * NARROW_W + g * MASK_GRAN;
            logic hit;
            assign hit = en_i && (lane_i == LANE_W'(l)) && mask_i[g];
            assign word_o[BASE +: MASK_GRAN] =
                hit ? data_i[g*MASK_GRAN +: MASK_GRAN] : word_i[BASE +: MASK_GRAN];
        end
    end

endmodule

// File: rtl/lane_ram_pick.sv
// Extracts one narrow lane from a wide word.
module lane_ram_pick #(
    parameter int unsigned WIDE_W   = 32,
    parameter int unsigned NARROW_W = 8,
    parameter int unsigned LANE_W   = 2
) (
    input  logic [WIDE_W-1:0]   word_i,
    input  logic [LANE_W-1:0]   lane_i,
    output logic [NARROW_W-1:0] data_o
);

    localparam int unsigned RATIO = WIDE_W / NARROW_W;

    logic [NARROW_W-1:0] slices [RATIO];

    for (genvar l = 0; l < RATIO; l++) begin : g_slice
        assign slices[l] = word_i[l*NARROW_W +: NARROW_W];
    end

    assign data_o = slices[lane_i];

endmodule

// File: rtl/lane_ram_rdreg.sv
// Enabled read-data register with synchronous clear.
module lane_ram_rdreg #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (en) q <= d;
    end

endmodule

// File: rtl/lane_ram.sv
module lane_ram
    import lane_ram_pkg::*;
#(
    parameter int unsigned WIDE_W    = 32,
    parameter int unsigned DEPTH     = 16,
    parameter int unsigned RATIO     = 4,
    parameter ruw_e        RUW       = RUW_READ_FIRST,
    localparam int unsigned NARROW_W = WIDE_W / RATIO,
    localparam int unsigned LANE_W   = $clog2(RATIO),
    localparam int unsigned WADDR_W  = $clog2(DEPTH),
    localparam int unsigned NADDR_W  = WADDR_W + LANE_W,
    localparam int unsigned MASK_W   = NARROW_W / MASK_GRAN
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wd_we,
    input  logic [WADDR_W-1:0]  wd_addr,
    input  logic [WIDE_W-1:0]   wd_wdata,
    input  logic                wd_re,
    output logic [WIDE_W-1:0]   wd_rdata,
    input  logic                nw_en,
    input  logic [NADDR_W-1:0]  nw_addr,
    input  logic [NARROW_W-1:0] nw_data,
    input  logic [MASK_W-1:0]   nw_mask,
    input  logic                nr_en,
    input  logic [NADDR_W-1:0]  nr_addr,
    output logic [NARROW_W-1:0] nr_rdata,
    input  logic                nx_en,
    input  logic                nx_wr,
    input  logic [NADDR_W-1:0]  nx_addr,
    input  logic [NARROW_W-1:0] nx_wdata,
    input  logic [MASK_W-1:0]   nx_mask,
    output logic [NARROW_W-1:0] nx_rdata
);

    // R12: configuration guard evaluated at elaboration.
    if (!is_pow2(RATIO) || RATIO < 2 || !is_pow2(DEPTH) ||
        (WIDE_W % RATIO) != 0 || (NARROW_W % MASK_GRAN) != 0) begin : g_bad_cfg
        $error("lane_ram: RATIO/DEPTH must be powers of two and lanes must split into mask groups");
    end

    // R2: split narrow addresses into word index and lane.
    logic [WADDR_W-1:0] nw_word, nr_word, nx_word;
    logic [LANE_W-1:0]  nw_lane, nr_lane, nx_lane;

    assign nw_word = nw_addr[NADDR_W-1:LANE_W];
    assign nw_lane = nw_addr[LANE_W-1:0];
    assign nr_word = nr_addr[NADDR_W-1:LANE_W];
    assign nr_lane = nr_addr[LANE_W-1:0];
    assign nx_word = nx_addr[NADDR_W-1:LANE_W];
    assign nx_lane = nx_addr[LANE_W-1:0];

    logic nx_we;
    assign nx_we = nx_en && nx_wr;

    // Storage and its next state.
    logic [WIDE_W-1:0] mem_q [DEPTH];
    logic [WIDE_W-1:0] mem_d [DEPTH];

    // R9: per word, wide write, then narrow write, then combined write.
    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        logic [WIDE_W-1:0] after_wide;
        logic [WIDE_W-1:0] after_nw;

        assign after_wide = (wd_we && wd_addr == WADDR_W'(i)) ? wd_wdata : mem_q[i];

        lane_ram_merge #(
            .WIDE_W  (WIDE_W),
            .NARROW_W(NARROW_W),
            .LANE_W  (LANE_W)
        ) u_nw_merge (
            .word_i(after_wide),
            .en_i  (nw_en && nw_word == WADDR_W'(i)),
            .lane_i(nw_lane),
            .data_i(nw_data),
            .mask_i(nw_mask),
            .word_o(after_nw)
        );

        lane_ram_merge #(
            .WIDE_W  (WIDE_W),
            .NARROW_W(NARROW_W),
            .LANE_W  (LANE_W)
        ) u_nx_merge (
            .word_i(after_nw),
            .en_i  (nx_we && nx_word == WADDR_W'(i)),
            .lane_i(nx_lane),
            .data_i(nx_wdata),
            .mask_i(nx_mask),
            .word_o(mem_d[i])
        );
    end

    // R1: synchronous clear of every word.
    always_ff @(posedge clk) begin
        if (rst) mem_q <= '{default: '0};
        else     mem_q <= mem_d;
    end

    // R10/R11: policy picks the pre-write or post-write image for reads.
    logic [WIDE_W-1:0] wd_src, nr_src, nx_src;

    if (RUW == RUW_WRITE_FIRST) begin : g_write_first
        assign wd_src = mem_d[wd_addr];
        assign nr_src = mem_d[nr_word];
        assign nx_src = mem_d[nx_word];
    end else begin : g_read_first
        assign wd_src = mem_q[wd_addr];
        assign nr_src = mem_q[nr_word];
        assign nx_src = mem_q[nx_word];
    end

    logic [NARROW_W-1:0] nr_lane_data, nx_lane_data;

    lane_ram_pick #(
        .WIDE_W  (WIDE_W),
        .NARROW_W(NARROW_W),
        .LANE_W  (LANE_W)
    ) u_nr_pick (
        .word_i(nr_src),
        .lane_i(nr_lane),
        .data_o(nr_lane_data)
    );

    lane_ram_pick #(
        .WIDE_W  (WIDE_W),
        .NARROW_W(NARROW_W),
        .LANE_W  (LANE_W)
    ) u_nx_pick (
        .word_i(nx_src),
        .lane_i(nx_lane),
        .data_o(nx_lane_data)
    );

    // R4/R5/R7: one-edge registered reads that hold while disabled.
    lane_ram_rdreg #(.W(WIDE_W)) u_wd_rd (
        .clk(clk), .rst(rst), .en(wd_re), .d(wd_src), .q(wd_rdata)
    );

    lane_ram_rdreg #(.W(NARROW_W)) u_nr_rd (
        .clk(clk), .rst(rst), .en(nr_en), .d(nr_lane_data), .q(nr_rdata)
    );

    lane_ram_rdreg #(.W(NARROW_W)) u_nx_rd (
        .clk(clk), .rst(rst), .en(nx_en), .d(nx_lane_data), .q(nx_rdata)
    );

endmodule

// File: rtl/lane_ram_chk.sv
module lane_ram_chk
    import lane_ram_pkg::*;
#(
    parameter int unsigned WIDE_W    = 32,
    parameter int unsigned DEPTH     = 16,
    parameter int unsigned RATIO     = 4,
    parameter ruw_e        RUW       = RUW_READ_FIRST,
    localparam int unsigned NARROW_W = WIDE_W / RATIO,
    localparam int unsigned LANE_W   = $clog2(RATIO),
    localparam int unsigned WADDR_W  = $clog2(DEPTH),
    localparam int unsigned NADDR_W  = WADDR_W + LANE_W,
    localparam int unsigned MASK_W   = NARROW_W / MASK_GRAN
) (
    input logic                clk,
    input logic                rst,
    input logic                wd_we,
    input logic                wd_re,
    input logic [WIDE_W-1:0]   wd_rdata,
    input logic                nw_en,
    input logic [NADDR_W-1:0]  nw_addr,
    input logic [NARROW_W-1:0] nw_data,
    input logic [MASK_W-1:0]   nw_mask,
    input logic                nr_en,
    input logic [NADDR_W-1:0]  nr_addr,
    input logic [NARROW_W-1:0] nr_rdata,
    input logic                nx_en,
    input logic                nx_wr,
    input logic [NARROW_W-1:0] nx_wdata,
    input logic [MASK_W-1:0]   nx_mask,
    input logic [NARROW_W-1:0] nx_rdata
);

    // R1
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (wd_rdata == '0 && nr_rdata == '0 && nx_rdata == '0));

    // R5
    a_r5_nr_hold: assert property (@(posedge clk) disable iff (rst)
        !nr_en |=> $stable(nr_rdata));

    // R5
    a_r5_wd_hold: assert property (@(posedge clk) disable iff (rst)
        !wd_re |=> $stable(wd_rdata));

    // R6
    a_r6_nx_hold: assert property (@(posedge clk) disable iff (rst)
        !nx_en |=> $stable(nx_rdata));

    // R3/R4: full-mask narrow write, read back of the same address next cycle
    a_r3_narrow_roundtrip: assert property (@(posedge clk) disable iff (rst)
        (nw_en && (&nw_mask) && !wd_we && !(nx_en && nx_wr))
        ##1 (nr_en && nr_addr == $past(nw_addr) && !wd_we && !nw_en && !(nx_en && nx_wr))
        |=> nr_rdata == $past(nw_data, 2));

    if (RUW == RUW_WRITE_FIRST) begin : g_wf_chk
        // R11
        a_r11_wf_new_data: assert property (@(posedge clk) disable iff (rst)
            (nx_en && nx_wr && (&nx_mask)) |=> nx_rdata == $past(nx_wdata));
    end

endmodule

bind lane_ram lane_ram_chk #(
    .WIDE_W(WIDE_W),
    .DEPTH (DEPTH),
    .RATIO (RATIO),
    .RUW   (RUW)
) u_lane_ram_chk (.*);

// File: tb/test_lane_ram.sv
`timescale 1ns/1ps
module test_lane_ram;
    import lane_ram_pkg::*;

    localparam int unsigned WIDE_W = 32;
    localparam int unsigned DEPTH  = 16;
    localparam int unsigned RATIO  = 4;
    localparam int unsigned NW     = WIDE_W / RATIO;
    localparam int unsigned WA     = $clog2(DEPTH);
    localparam int unsigned NA     = WA + $clog2(RATIO);
    localparam int unsigned MW     = NW / MASK_GRAN;

    localparam logic [1:0] OP_WW = 2'd0, OP_NW = 2'd1, OP_NR = 2'd2, OP_WR = 2'd3;

    typedef struct packed {
        logic [1:0]  op;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [1:0]  mask;
        logic [31:0] exp;
    } vec_t;

    // R2/R3/R7/R8 vector table: op, address, data, mask, expected read
    localparam int NVEC = 16;
    localparam vec_t VECS [NVEC] = '{
        '{OP_WW, 8'd3,  32'hA1B2C3D4, 2'b00, 32'h0},
        '{OP_NR, 8'd12, 32'h0,        2'b00, 32'h000000D4},
        '{OP_NR, 8'd13, 32'h0,        2'b00, 32'h000000C3},
        '{OP_NR, 8'd14, 32'h0,        2'b00, 32'h000000B2},
        '{OP_NR, 8'd15, 32'h0,        2'b00, 32'h000000A1},
        '{OP_NW, 8'd13, 32'h5E,       2'b11, 32'h0},
        '{OP_WR, 8'd3,  32'h0,        2'b00, 32'hA1B25ED4},
        '{OP_NW, 8'd14, 32'h77,       2'b01, 32'h0},
        '{OP_WR, 8'd3,  32'h0,        2'b00, 32'hA1B75ED4},
        '{OP_NW, 8'd0,  32'h9C,       2'b10, 32'h0},
        '{OP_WR, 8'd0,  32'h0,        2'b00, 32'h00000090},
        '{OP_NR, 8'd0,  32'h0,        2'b00, 32'h00000090},
        '{OP_WW, 8'd15, 32'hFFFFFFFF, 2'b00, 32'h0},
        '{OP_NW, 8'd63, 32'h00,       2'b11, 32'h0},
        '{OP_WR, 8'd15, 32'h0,        2'b00, 32'h00FFFFFF},
        '{OP_NR, 8'd60, 32'h0,        2'b00, 32'h000000FF}
    };

    logic clk = 1'b0;
    logic rst;
    logic          wd_we, wd_re;
    logic [WA-1:0] wd_addr;
    logic [31:0]   wd_wdata;
    logic          nw_en, nr_en, nx_en, nx_wr;
    logic [NA-1:0] nw_addr, nr_addr, nx_addr;
    logic [NW-1:0] nw_data, nx_wdata;
    logic [MW-1:0] nw_mask, nx_mask;

    logic [31:0]   wd_rdata_rf, wd_rdata_wf;
    logic [NW-1:0] nr_rdata_rf, nr_rdata_wf, nx_rdata_rf, nx_rdata_wf;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    lane_ram #(.WIDE_W(WIDE_W), .DEPTH(DEPTH), .RATIO(RATIO), .RUW(RUW_READ_FIRST)) i_lane_ram (
        .clk(clk), .rst(rst),
        .wd_we(wd_we), .wd_addr(wd_addr), .wd_wdata(wd_wdata), .wd_re(wd_re), .wd_rdata(wd_rdata_rf),
        .nw_en(nw_en), .nw_addr(nw_addr), .nw_data(nw_data), .nw_mask(nw_mask),
        .nr_en(nr_en), .nr_addr(nr_addr), .nr_rdata(nr_rdata_rf),
        .nx_en(nx_en), .nx_wr(nx_wr), .nx_addr(nx_addr), .nx_wdata(nx_wdata), .nx_mask(nx_mask),
        .nx_rdata(nx_rdata_rf)
    );

    lane_ram #(.WIDE_W(WIDE_W), .DEPTH(DEPTH), .RATIO(RATIO), .RUW(RUW_WRITE_FIRST)) i_lane_ram_wf (
        .clk(clk), .rst(rst),
        .wd_we(wd_we), .wd_addr(wd_addr), .wd_wdata(wd_wdata), .wd_re(wd_re), .wd_rdata(wd_rdata_wf),
        .nw_en(nw_en), .nw_addr(nw_addr), .nw_data(nw_data), .nw_mask(nw_mask),
        .nr_en(nr_en), .nr_addr(nr_addr), .nr_rdata(nr_rdata_wf),
        .nx_en(nx_en), .nx_wr(nx_wr), .nx_addr(nx_addr), .nx_wdata(nx_wdata), .nx_mask(nx_mask),
        .nx_rdata(nx_rdata_wf)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        wd_we = 1'b0; wd_re = 1'b0; nw_en = 1'b0; nr_en = 1'b0; nx_en = 1'b0; nx_wr = 1'b0;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired before the run completed");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst = 1'b1;
        idle();
        wd_addr = '0; wd_wdata = '0; nw_addr = '0; nw_data = '0; nw_mask = '0;
        nr_addr = '0; nx_addr = '0; nx_wdata = '0; nx_mask = '0;
        repeat (3) step();
        check("R1 wide out in reset", wd_rdata_rf, 32'h0);
        check("R1 narrow out in reset", {24'h0, nr_rdata_rf}, 32'h0);
        check("R1 combined out in reset", {24'h0, nx_rdata_wf}, 32'h0);
        rst = 1'b0;
        step();

        // R1: storage cleared
        nr_en = 1'b1; nr_addr = NA'(21);
        step();
        idle();
        check("R1 word cleared", {24'h0, nr_rdata_rf}, 32'h0);

        // Table walk (R2, R3, R7, R8)
        for (int k = 0; k < NVEC; k++) begin
            idle();
            case (VECS[k].op)
                OP_WW: begin wd_we = 1'b1; wd_addr = WA'(VECS[k].addr); wd_wdata = VECS[k].data; end
                OP_NW: begin nw_en = 1'b1; nw_addr = NA'(VECS[k].addr); nw_data = NW'(VECS[k].data);
                             nw_mask = VECS[k].mask; end
                OP_NR: begin nr_en = 1'b1; nr_addr = NA'(VECS[k].addr); end
                default: begin wd_re = 1'b1; wd_addr = WA'(VECS[k].addr); end
            endcase
            step();
            idle();
            if (VECS[k].op == OP_NR) begin
                check("R2/R8 narrow lane read", {24'h0, nr_rdata_rf}, VECS[k].exp);
                check("R2/R8 narrow lane read wf", {24'h0, nr_rdata_wf}, VECS[k].exp);
            end else if (VECS[k].op == OP_WR) begin
                check("R3/R7 wide read after narrow write", wd_rdata_rf, VECS[k].exp);
                check("R3/R7 wide read after narrow write wf", wd_rdata_wf, VECS[k].exp);
            end
        end

        // R4 latency, then R5 hold with changed address
        nr_en = 1'b1; nr_addr = NA'(12);
        step();
        check("R4 narrow read one edge", {24'h0, nr_rdata_rf}, 32'hD4);
        nr_en = 1'b0; nr_addr = NA'(13);
        step();
        check("R5 narrow read holds", {24'h0, nr_rdata_rf}, 32'hD4);
        wd_re = 1'b0; wd_addr = WA'(0);
        step();
        check("R5 wide read holds", wd_rdata_rf, 32'h00FFFFFF);

        // R6/R10/R11 combined port collision on word 5 lane 0
        nx_en = 1'b1; nx_wr = 1'b1; nx_addr = NA'(20); nx_wdata = 8'h3C; nx_mask = 2'b11;
        step();
        check("R10 combined read-first old", {24'h0, nx_rdata_rf}, 32'h00);
        check("R11 combined write-first new", {24'h0, nx_rdata_wf}, 32'h3C);
        nx_wr = 1'b0;
        step();
        check("R6 combined read", {24'h0, nx_rdata_rf}, 32'h3C);
        nx_wr = 1'b1; nx_wdata = 8'hFF; nx_mask = 2'b00;
        step();
        check("R6 zero mask read-first", {24'h0, nx_rdata_rf}, 32'h3C);
        check("R6 zero mask write-first", {24'h0, nx_rdata_wf}, 32'h3C);
        nx_wr = 1'b0;
        step();
        check("R6 zero mask kept data", {24'h0, nx_rdata_rf}, 32'h3C);
        idle();

        // R10/R11 narrow read against wide write, word 6 lane 1
        wd_we = 1'b1; wd_addr = WA'(6); wd_wdata = 32'h11223344;
        nr_en = 1'b1; nr_addr = NA'(25);
        step();
        idle();
        check("R10 narrow read-first old", {24'h0, nr_rdata_rf}, 32'h00);
        check("R11 narrow write-first new", {24'h0, nr_rdata_wf}, 32'h33);

        // R9 three writes to word 7 in one cycle
        wd_we = 1'b1; wd_addr = WA'(7); wd_wdata = 32'hAAAAAAAA;
        nw_en = 1'b1; nw_addr = NA'(28); nw_data = 8'h11; nw_mask = 2'b11;
        nx_en = 1'b1; nx_wr = 1'b1; nx_addr = NA'(28); nx_wdata = 8'h22; nx_mask = 2'b01;
        step();
        idle();
        wd_re = 1'b1; wd_addr = WA'(7);
        step();
        idle();
        check("R9 write order", wd_rdata_rf, 32'hAAAAAA12);
        check("R9 write order wf", wd_rdata_wf, 32'hAAAAAA12);

        // R12 ratio legality function
        check("R12 ratio 3 rejected", {31'h0, is_pow2(3)}, 32'h0);
        check("R12 ratio 4 accepted", {31'h0, is_pow2(4)}, 32'h1);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule